// File: doc/BRIEF.md
# Dual Store Queue Write-Combining Buffer

This block sits between a CPU store path and external memory. It holds two queues of eight 32-bit words each. The CPU fills a queue by storing into a fixed address window. It then issues a prefetch to that queue's window address, and the block sends the whole queue to memory as one 32-byte burst. Bit 5 of the store address picks the queue and bits [4:2] pick the word inside it. Bits [25:6] of the store address are don't-care, so the store port carries only the region tag (address bits [31:26]) and the low offset (address bits [5:0]).

Each queue has its own 3-bit area register. At the moment a prefetch is accepted, that register value and prefetch address bits [25:5] are captured to form a 29-bit, 32-byte-aligned physical destination. A burst is one header beat carrying that destination, followed by eight data beats, all on a valid/ready channel. While a queue is being flushed, any store or prefetch aimed at it is held off, so software can wait for completion by simply storing again. The two queues flush independently. When both are waiting, SQ0 goes first.

Top module: `stq_combiner`

## Requirements
- R1: A store or prefetch is in the window only when its address bits [31:26] equal 6'b111000. A store outside the window writes nothing, raises neither stStall nor stAddrErr, and is accepted at once. A prefetch outside the window starts no burst.
- R2: For a window store, offset bit 5 selects the queue (0 = SQ0, 1 = SQ1) and offset bits [4:2] select the word slot 0..7. A longword store (stQuad=0) writes stData[31:0] into that slot.
- R3: A quadword store (stQuad=1) with offset bit 2 = 0 writes stData[31:0] into the even slot and stData[63:32] into the next, odd slot.
- R4: A window store with offset bits [1:0] nonzero, or a quadword store with offset bit 2 = 1, raises stAddrErr in the same cycle. It writes nothing and is not stalled.
- R5: When areaWe is high, areaField is written into the area register of the queue given by areaSel (0 = SQ0, 1 = SQ1).
- R6: An accepted window prefetch starts a flush of the queue given by pfAddr[5]. The first beat has bHdr=1 and bData = {3'b000, area[2:0], pfAddr[25:5], 5'b00000}.
- R7: After the header come eight beats carrying slots 0 to 7 in ascending order, with bLast=1 only on slot 7. Each beat advances only when bValid and bReady are both high, and bData, bHdr and bLast hold while bValid is high and bReady is low.
- R8: From the acceptance of a prefetch until its eighth data beat is accepted, a window store or prefetch aimed at that queue sees stStall or pfStall high and has no effect. Afterwards it is accepted.
- R9: SQ1 accepts stores and a prefetch while SQ0 is flushing. A queued flush goes out after the active burst, and SQ0 wins when both are waiting.
- R10: The area value and the prefetch address are captured when the prefetch is accepted. A later area write does not change that burst's header.
- R11: After reset, bValid, stStall, pfStall and stAddrErr are low and both area registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Store request |
| stRegion | input | 6 | Store address bits [31:26] |
| stOffset | input | 6 | Store address bits [5:0] |
| stData | input | 64 | Store data; only [31:0] are used for a longword |
| stQuad | input | 1 | 1 = quadword store, 0 = longword store |
| stStall | output | 1 | Store held off because the target queue is flushing |
| stAddrErr | output | 1 | Misaligned window store; the store is dropped |
| pfValid | input | 1 | Prefetch request |
| pfAddr | input | 27 | Prefetch address bits [31:5] |
| pfStall | output | 1 | Prefetch held off because the target queue is flushing |
| areaWe | input | 1 | Area register write strobe |
| areaSel | input | 1 | Area register select |
| areaField | input | 3 | New area value |
| bValid | output | 1 | Burst beat valid |
| bReady | input | 1 | Burst beat accepted |
| bHdr | output | 1 | Beat is the address header |
| bLast | output | 1 | Beat is the eighth data beat |
| bData | output | 32 | Header address or data word |

## Verification
The bench builds the block with its default window tag of 6'b111000 and the package's eight-slot, two-queue shape. That shape makes every slot, both queues and the full header layout visible within a few hundred cycles. With the burst port held not ready, the bench can keep SQ0 busy for as long as it needs. During that time it probes the stall outputs, rewrites the area register, and fills and queues SQ1, so that the snapshot and back-to-back ordering show up in the header and data beats. It then releases the port with a pseudo-random ready pattern, which exercises the hold rule on every beat position.

// File: rtl/sqb_pkg.sv
package sqb_pkg;
  localparam int SQ_NUM   = 2;
  localparam int SQ_SLOTS = 8;
  localparam int SLOT_W   = $clog2(SQ_SLOTS);
  localparam int BEAT_W   = $clog2(SQ_SLOTS + 1);
  localparam int WORD_W   = 32;
  localparam int AREA_W   = 3;
  localparam int LINE_W   = 21;
  localparam int ALIGN_W  = 5;
  localparam int PHYS_W   = AREA_W + LINE_W + ALIGN_W;

  typedef struct packed {
    logic              wrEn;
    logic              wrQ;
    logic [SLOT_W-1:0] wrSlot;
    logic              wrQuad;
    logic              pfTake;
    logic              pfQ;
    logic              curQ;
    logic [BEAT_W-1:0] beat;
  } sqCtl_t;
endpackage

// File: rtl/sqb_ctrl.sv
module sqb_ctrl
  import sqb_pkg::*;
#(
  parameter logic [5:0] WINDOW_TAG = 6'b111000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stValid,
  input  logic [5:0] stRegion,
  input  logic [5:0] stOffset,
  input  logic       stQuad,
  input  logic       pfValid,
  input  logic [5:0] pfRegion,
  input  logic       pfSel,
  input  logic       bReady,
  output logic       stStall,
  output logic       stAddrErr,
  output logic       pfStall,
  output logic       bValid,
  output logic       bHdr,
  output logic       bLast,
  output sqCtl_t     ctl
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(SQ_SLOTS);

  logic [SQ_NUM-1:0] busy, busyNx;
  logic              act, curQ;
  logic [BEAT_W-1:0] beat;
  logic stWin, stBad, stQ, pfWin, pfTake, done;

  assign stWin = (stRegion == WINDOW_TAG);
  assign stBad = (stOffset[1:0] != 2'b00) | (stQuad & stOffset[2]);
  assign stQ   = stOffset[5];
  assign stAddrErr = stValid & stWin & stBad;
  assign stStall   = stValid & stWin & ~stBad & busy[stQ];

  assign pfWin   = (pfRegion == WINDOW_TAG);
  assign pfStall = pfValid & pfWin & busy[pfSel];
  assign pfTake  = pfValid & pfWin & ~busy[pfSel];

  assign done = act & bReady & (beat == LAST_BEAT);

  always_comb begin
    busyNx = busy;
    if (done)   busyNx[curQ] = 1'b0;
    if (pfTake) busyNx[pfSel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= '0;
      act  <= 1'b0;
      curQ <= 1'b0;
      beat <= '0;
    end else begin
      busy <= busyNx;
      if (!act) begin
        if (|busy) begin
          act  <= 1'b1;
          curQ <= ~busy[0];
          beat <= '0;
        end
      end else if (bReady) begin
        if (beat == LAST_BEAT) act <= 1'b0;
        else beat <= beat + 1'b1;
      end
    end
  end

  assign bValid = act;
  assign bHdr   = act & (beat == '0);
  assign bLast  = act & (beat == LAST_BEAT);

  always_comb begin
    ctl.wrEn   = stValid & stWin & ~stBad & ~busy[stQ];
    ctl.wrQ    = stQ;
    ctl.wrSlot = stOffset[SLOT_W+1:2];
    ctl.wrQuad = stQuad;
    ctl.pfTake = pfTake;
    ctl.pfQ    = pfSel;
    ctl.curQ   = curQ;
    ctl.beat   = beat;
  end
endmodule

// File: rtl/sqb_datapath.sv
module sqb_datapath
  import sqb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  sqCtl_t            ctl,
  input  logic [63:0]       stData,
  input  logic              areaWe,
  input  logic              areaSel,
  input  logic [AREA_W-1:0] areaField,
  input  logic [LINE_W-1:0] pfLine,
  output logic [WORD_W-1:0] bData
);
  localparam int DEST_W = AREA_W + LINE_W;

  logic [WORD_W-1:0] qMem [SQ_NUM][SQ_SLOTS];
  logic [AREA_W-1:0] area [SQ_NUM];
  logic [DEST_W-1:0] dest [SQ_NUM];
  logic [SLOT_W-1:0] rdSlot;

  always_ff @(posedge clk) begin
    if (ctl.wrEn) begin
      if (ctl.wrQuad) begin
        qMem[ctl.wrQ][{ctl.wrSlot[SLOT_W-1:1], 1'b0}] <= stData[31:0];
        qMem[ctl.wrQ][{ctl.wrSlot[SLOT_W-1:1], 1'b1}] <= stData[63:32];
      end else begin
        qMem[ctl.wrQ][ctl.wrSlot] <= stData[31:0];
      end
    end
  end

  for (genvar g = 0; g < SQ_NUM; g++) begin : gQueue
    always_ff @(posedge clk) begin
      if (!rstN) begin
        area[g] <= '0;
        dest[g] <= '0;
      end else begin
        if (areaWe && (areaSel == 1'(g))) area[g] <= areaField;
        if (ctl.pfTake && (ctl.pfQ == 1'(g))) dest[g] <= {area[g], pfLine};
      end
    end
  end

  assign rdSlot = SLOT_W'(ctl.beat - 1'b1);

  always_comb begin
    if (ctl.beat == '0)
      bData = {{(WORD_W-PHYS_W){1'b0}}, dest[ctl.curQ], {ALIGN_W{1'b0}}};
    else
      bData = qMem[ctl.curQ][rdSlot];
  end
endmodule

// File: rtl/stq_combiner.sv
module stq_combiner
  import sqb_pkg::*;
#(
  parameter logic [5:0] WINDOW_TAG = 6'b111000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        stValid,
  input  logic [5:0]  stRegion,
  input  logic [5:0]  stOffset,
  input  logic [63:0] stData,
  input  logic        stQuad,
  output logic        stStall,
  output logic        stAddrErr,
  input  logic        pfValid,
  input  logic [31:5] pfAddr,
  output logic        pfStall,
  input  logic        areaWe,
  input  logic        areaSel,
  input  logic [2:0]  areaField,
  output logic        bValid,
  input  logic        bReady,
  output logic        bHdr,
  output logic        bLast,
  output logic [31:0] bData
);
  sqCtl_t ctl;

  sqb_ctrl #(.WINDOW_TAG(WINDOW_TAG)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .stValid(stValid), .stRegion(stRegion), .stOffset(stOffset), .stQuad(stQuad),
    .pfValid(pfValid), .pfRegion(pfAddr[31:26]), .pfSel(pfAddr[5]),
    .bReady(bReady),
    .stStall(stStall), .stAddrErr(stAddrErr), .pfStall(pfStall),
    .bValid(bValid), .bHdr(bHdr), .bLast(bLast), .ctl(ctl)
  );

  sqb_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stData(stData),
    .areaWe(areaWe), .areaSel(areaSel), .areaField(areaField),
    .pfLine(pfAddr[25:5]), .bData(bData)
  );
endmodule

// File: rtl/sqb_chk.sv
module sqb_chk (
  input logic        clk,
  input logic        rstN,
  input logic        stValid,
  input logic        stStall,
  input logic        stAddrErr,
  input logic        pfValid,
  input logic        pfStall,
  input logic        bValid,
  input logic        bReady,
  input logic        bHdr,
  input logic        bLast,
  input logic [31:0] bData
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    bValid && !bReady |=> bValid && $stable(bData) && $stable(bHdr) && $stable(bLast));

  p_hdr_after_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    bValid && bReady && bLast |=> !bValid || bHdr);

  p_hdr_form_r6: assert property (@(posedge clk) disable iff (!rstN)
    bValid && bHdr |-> bData[31:29] == 3'b000 && bData[4:0] == 5'b00000);

  p_err_no_stall_r4: assert property (@(posedge clk) disable iff (!rstN)
    stAddrErr |-> !stStall);

  p_st_stall_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    stStall |-> stValid);

  p_pf_stall_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    pfStall |-> pfValid);
endmodule

bind stq_combiner sqb_chk u_chk (
  .clk(clk), .rstN(rstN), .stValid(stValid), .stStall(stStall), .stAddrErr(stAddrErr),
  .pfValid(pfValid), .pfStall(pfStall), .bValid(bValid), .bReady(bReady),
  .bHdr(bHdr), .bLast(bLast), .bData(bData)
);

// File: tb/sim_stq_combiner.sv
`timescale 1ns/1ps
module sim_stq_combiner;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stValid = 1'b0;
  logic [5:0]  stRegion = '0;
  logic [5:0]  stOffset = '0;
  logic [63:0] stData = '0;
  logic        stQuad = 1'b0;
  logic        stStall, stAddrErr;
  logic        pfValid = 1'b0;
  logic [31:5] pfAddr = '0;
  logic        pfStall;
  logic        areaWe = 1'b0;
  logic        areaSel = 1'b0;
  logic [2:0]  areaField = '0;
  logic        bValid, bHdr, bLast;
  logic        bReady = 1'b0;
  logic [31:0] bData;

  always #2.5 clk = ~clk;

  stq_combiner u0 (.*);

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [2][8];
  logic [2:0]  mdlArea [2];
  logic [33:0] expq [$];
  int   rdyMode = 0;
  logic [7:0] lf = 8'h5B;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doArea(input logic sel, input logic [2:0] val);
    @(negedge clk);
    areaWe = 1'b1; areaSel = sel; areaField = val;
    @(posedge clk); #1;
    areaWe = 1'b0;
    mdlArea[sel] = val;
  endtask

  // Store: model applies R1..R4 decode; stAddrErr is compared on every store.
  task automatic doStore(input logic [5:0] reg6, input logic [5:0] off, input logic [63:0] d,
                         input logic quad, input string tag);
    bit win, bad;
    win = (reg6 == 6'b111000);
    bad = (off[1:0] != 2'b00) || (quad && off[2]);
    @(negedge clk);
    stValid = 1'b1; stRegion = reg6; stOffset = off; stData = d; stQuad = quad;
    #1;
    chk(stAddrErr == (win && bad), tag, 64'(stAddrErr), 64'(win && bad));
    while (stStall) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    stValid = 1'b0;
    if (win && !bad) begin
      if (quad) begin
        mdl[off[5]][{off[4:3], 1'b0}] = d[31:0];
        mdl[off[5]][{off[4:3], 1'b1}] = d[63:32];
      end else begin
        mdl[off[5]][off[4:2]] = d[31:0];
      end
    end
  endtask

  task automatic doPf(input logic [31:0] a);
    @(negedge clk);
    pfValid = 1'b1; pfAddr = a[31:5];
    #1;
    while (pfStall) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    pfValid = 1'b0;
    if (a[31:26] == 6'b111000) begin
      expq.push_back({2'b10, 3'b000, mdlArea[a[5]], a[25:5], 5'b00000});
      for (int i = 0; i < 8; i++)
        expq.push_back({1'b0, (i == 7), mdl[a[5]][i]});
    end
  endtask

  task automatic drain();
    @(negedge clk);
    while (expq.size() != 0 || bValid) @(negedge clk);
  endtask

  // Ready driver, changes just after each rising edge.
  initial forever begin
    @(posedge clk); #1;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    bReady = (rdyMode == 1) ? 1'b1 : (rdyMode == 2) ? lf[0] : 1'b0;
  end

  // Monitor / scoreboard: R6, R7, R9, R10 on every accepted beat.
  initial forever begin
    @(negedge clk);
    if (rstN && bValid && bReady) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R7 unexpected beat", 64'(bData), 64'h0);
      end else begin
        logic [33:0] e;
        e = expq.pop_front();
        chk({bHdr, bLast, bData} == e, e[33] ? "R6/R10 header" : "R7/R9 data beat",
            64'({bHdr, bLast, bData}), 64'(e));
      end
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    chk(1'b0, "watchdog", 64'h0, 64'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int q = 0; q < 2; q++) begin
      mdlArea[q] = 3'b000;
      for (int i = 0; i < 8; i++) mdl[q][i] = 32'h0;
    end
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(!bValid && !stStall && !pfStall && !stAddrErr, "R11 reset outputs",
        64'({bValid, stStall, pfStall, stAddrErr}), 64'h0);

    // Clear queue contents so the model starts defined.
    for (int i = 0; i < 8; i++) begin
      doStore(6'b111000, {1'b0, 3'(i), 2'b00}, 64'h0, 1'b0, "R2 clear SQ0");
      doStore(6'b111000, {1'b1, 3'(i), 2'b00}, 64'h0, 1'b0, "R2 clear SQ1");
    end

    doArea(1'b0, 3'b101);   // R5
    doArea(1'b1, 3'b010);   // R5

    for (int i = 0; i < 8; i++)
      doStore(6'b111000, {1'b0, 3'(i), 2'b00}, {32'hFFFF_FFFF, 32'hA000_0000 + 32'(i)}, 1'b0, "R2 longword");

    // R1: stores outside the window are ignored and not stalled.
    doStore(6'b111001, 6'b000000, 64'hDEAD, 1'b0, "R1 outside tag");
    doStore(6'b011000, 6'b000100, 64'hBEEF, 1'b0, "R1 outside tag");
    // R4: misaligned stores are flagged and dropped.
    doStore(6'b111000, 6'b000010, 64'hBAD0, 1'b0, "R4 low bits");
    doStore(6'b111000, 6'b010100, 64'hBAD1_BAD2, 1'b1, "R4 quad odd slot");

    // R1: a prefetch outside the window starts nothing.
    rdyMode = 1;
    doPf(32'hE400_0000);
    repeat (6) @(negedge clk);
    chk(!bValid, "R1 outside prefetch", 64'(bValid), 64'h0);

    // SQ0 flush with the port stalled.
    rdyMode = 0;
    repeat (2) @(negedge clk);
    doPf(32'hE123_4540);
    repeat (3) @(negedge clk);
    chk(bValid && bHdr, "R6 header presented", 64'({bValid, bHdr}), 64'h3);

    @(negedge clk);
    stValid = 1'b1; stRegion = 6'b111000; stOffset = 6'b001000; stData = 64'h5555; stQuad = 1'b0;
    #1 chk(stStall, "R8 store stalled while busy", 64'(stStall), 64'h1);
    stValid = 1'b0;
    pfValid = 1'b1; pfAddr = 27'(32'hE000_0000 >> 5);
    #1 chk(pfStall, "R8 prefetch stalled while busy", 64'(pfStall), 64'h1);
    pfValid = 1'b0;

    doArea(1'b0, 3'b000);   // R10: must not alter the pending header

    // R9/R3: SQ1 fills with quadword stores while SQ0 is busy.
    for (int k = 0; k < 4; k++)
      doStore(6'b111000, {1'b1, 2'(k), 1'b0, 2'b00},
              {32'hB100_0001 + 32'(2*k), 32'hB100_0000 + 32'(2*k)}, 1'b1, "R3 quad");
    doPf(32'hE123_4560);

    rdyMode = 2;
    drain();

    // R8: after completion SQ0 accepts stores again.
    doStore(6'b111000, 6'b000000, 64'hC000_0000, 1'b0, "R8 store after done");
    doStore(6'b111000, 6'b011000, 64'hC000_0007_C000_0006, 1'b1, "R3 quad after done");
    rdyMode = 1;
    doPf(32'hE3FF_FFC0);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule